// File: doc/BRIEF.md
# Link Start Transition Detector

This block sits on one received lane once code-group synchronization has been reached. It watches the stream of decoded octets and finds the exact octet where the run of /K/ comma characters (K28.5, 0xBC with the control flag set) ends and the link proper begins. A static configuration input picks what counts as a correct start. In aligned-start mode the comma run must be followed by the /R/ control character (K28.0, 0x1C with the control flag set). In direct-start mode it must be followed by an ordinary data octet.

When the expected transition occurs, the block gives a one-cycle start pulse. It also raises a check-blanking mask for a fixed number of valid octets. Downstream data checkers use the mask to ignore octets that later stages (character replacement, descrambling) cannot yet deliver reliably. When the comma run ends with anything else, two sticky error flags are raised and the detector goes back to hunting for commas. A synchronous re-initialization input restarts the search without touching the error flags. A separate clear input resets the flags.

Top module: `lane_start_detect`

## Requirements
- R1: After the synchronous reset `rst`, `start_pulse`, `chk_mask`, `err_ilas` and `err_unexp_k` are all 0, and the detector waits for a first /K/ (control flag 1, octet 0xBC).
- R2: With `lane_sync_en`=1, a /K/ followed by /R/ (control flag 1, octet 0x1C) on the next valid octet raises `start_pulse` in the clock cycle after /R/ is accepted, for exactly one cycle.
- R3: With `lane_sync_en`=1, a /K/ run that ends in anything other than /K/ or /R/ sets both `err_ilas` and `err_unexp_k`, gives no start pulse, and returns the detector to waiting for /K/.
- R4: With `lane_sync_en`=0, a /K/ run followed by an octet with control flag 0 raises `start_pulse` in the cycle after that octet is accepted.
- R5: With `lane_sync_en`=0, a /K/ run that ends in a control character other than /K/ (including /R/) sets both error flags, gives no start, and returns the detector to waiting for /K/.
- R6: Valid octets seen before any /K/ neither start the link nor set an error.
- R7: With `lane_sync_en`=0, `chk_mask` rises together with `start_pulse` and stays high for the 16 valid octets that follow the start octet. It falls in the cycle after the 16th of them.
- R8: With `lane_sync_en`=1, the mask length is `DSCR_MASK_LEN` valid octets when `DESCRAMBLE_EN`=1, and `PLAIN_MASK_LEN` otherwise, with the same timing as R7.
- R9: A /K/ accepted after the start sets `err_unexp_k` only, and leaves `err_ilas` unchanged.
- R10: Error flags stay set until `err_clear` is high at a clock edge. A new error in that same cycle wins over the clear.
- R11: `reinit` returns the detector to waiting for /K/ and clears `start_pulse` and `chk_mask` on the next cycle. It leaves the error flags as they are.
- R12: Cycles with `rx_valid`=0 do not advance the detector state or the mask count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reinit | input | 1 | Synchronous restart of the search for /K/ |
| lane_sync_en | input | 1 | 1: start is /K/ to /R/; 0: start is /K/ to data |
| rx_valid | input | 1 | Octet strobe |
| rx_is_ctrl | input | 1 | Octet is a control character |
| rx_data | input | 8 | Decoded octet |
| err_clear | input | 1 | Clears the sticky error flags |
| start_pulse | output | 1 | One-cycle start indication |
| chk_mask | output | 1 | High while data checking must be suppressed |
| err_ilas | output | 1 | Sticky: wrong transition out of the /K/ run |
| err_unexp_k | output | 1 | Sticky: /K/ where it is not allowed |
| | | | |

## Verification
The bench builds the block with its default parameters: an octet width of 8, `DESCRAMBLE_EN`=1, `DSCR_MASK_LEN`=8 and a direct-start length of 16. These values bring both mask lengths within reach, and each can be counted down octet by octet within a short run. Both start modes are driven, and so are stray control characters that end the comma run. Gaps in the strobe are placed inside the mask window. A clear and a new error are made to collide in the same cycle.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_KRUN = 2'd1,
    ST_LIVE = 2'd2
  } lsd_state_e;

  localparam logic [7:0] COMMA_OCTET = 8'hBC;
  localparam logic [7:0] RSTART_OCTET = 8'h1C;

  localparam int ERR_IDX_ILAS = 0;
  localparam int ERR_IDX_UNK  = 1;
  localparam int ERR_COUNT    = 2;
endpackage

// File: rtl/lsd_fsm.sv
module lsd_fsm
  import lsd_pkg::*;
#(
  parameter int OCT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reinit,
  input  logic             sync_en,
  input  logic             valid,
  input  logic             is_ctrl,
  input  logic [OCT_W-1:0] octet,
  output logic             start_evt,
  output logic             viol_evt,
  output logic             late_k_evt,
  output logic             start_q
);
  lsd_state_e state_q, state_d;
  logic is_k, is_r, good_exit;

  always_comb begin
    is_k       = is_ctrl && (octet == OCT_W'(COMMA_OCTET));
    is_r       = is_ctrl && (octet == OCT_W'(RSTART_OCTET));
    good_exit  = sync_en ? is_r : !is_ctrl;
    state_d    = state_q;
    start_evt  = 1'b0;
    viol_evt   = 1'b0;
    late_k_evt = 1'b0;
    if (valid && !reinit) begin
      unique case (state_q)
        ST_HUNT: if (is_k) state_d = ST_KRUN;
        ST_KRUN: begin
          if (!is_k) begin
            if (good_exit) begin
              start_evt = 1'b1;
              state_d   = ST_LIVE;
            end else begin
              viol_evt = 1'b1;
              state_d  = ST_HUNT;
            end
          end
        end
        ST_LIVE: if (is_k) late_k_evt = 1'b1;
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || reinit) begin
      state_q <= ST_HUNT;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_evt;
    end
  end
endmodule

// File: rtl/lsd_mask_timer.sv
module lsd_mask_timer #(
  parameter int LEN_DIRECT  = 16,
  parameter int LEN_ALIGNED = 8,
  localparam int LEN_MAX    = (LEN_DIRECT > LEN_ALIGNED) ? LEN_DIRECT : LEN_ALIGNED,
  localparam int CNT_W      = $clog2(LEN_MAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic reinit,
  input  logic load,
  input  logic sync_en,
  input  logic adv,
  output logic mask_q
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    load_val = sync_en ? CNT_W'(LEN_ALIGNED) : CNT_W'(LEN_DIRECT);
  end

  always_ff @(posedge clk) begin
    if (rst || reinit) begin
      cnt_q  <= '0;
      mask_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= load_val;
      mask_q <= (load_val != '0);
    end else if (adv && (cnt_q != '0)) begin
      cnt_q  <= cnt_q - 1'b1;
      mask_q <= (cnt_q != CNT_W'(1));
    end
  end
endmodule

// File: rtl/lsd_err_flags.sv
module lsd_err_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flag_q[i] <= 1'b0;
      else if (set[i]) flag_q[i] <= 1'b1;
      else if (clr)    flag_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/lane_start_detect.sv
module lane_start_detect
  import lsd_pkg::*;
#(
  parameter int OCT_W          = 8,
  parameter bit DESCRAMBLE_EN  = 1'b1,
  parameter int DSCR_MASK_LEN  = 8,
  parameter int PLAIN_MASK_LEN = 2,
  parameter int DIRECT_MASK_LEN = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reinit,
  input  logic             lane_sync_en,
  input  logic             rx_valid,
  input  logic             rx_is_ctrl,
  input  logic [OCT_W-1:0] rx_data,
  input  logic             err_clear,
  output logic             start_pulse,
  output logic             chk_mask,
  output logic             err_ilas,
  output logic             err_unexp_k
);
  localparam int ALIGNED_LEN = DESCRAMBLE_EN ? DSCR_MASK_LEN : PLAIN_MASK_LEN;

  logic start_evt, viol_evt, late_k_evt;
  logic [ERR_COUNT-1:0] err_set, err_q;

  lsd_fsm #(.OCT_W(OCT_W)) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .reinit    (reinit),
    .sync_en   (lane_sync_en),
    .valid     (rx_valid),
    .is_ctrl   (rx_is_ctrl),
    .octet     (rx_data),
    .start_evt (start_evt),
    .viol_evt  (viol_evt),
    .late_k_evt(late_k_evt),
    .start_q   (start_pulse)
  );

  lsd_mask_timer #(
    .LEN_DIRECT (DIRECT_MASK_LEN),
    .LEN_ALIGNED(ALIGNED_LEN)
  ) mask_i (
    .clk    (clk),
    .rst    (rst),
    .reinit (reinit),
    .load   (start_evt),
    .sync_en(lane_sync_en),
    .adv    (rx_valid),
    .mask_q (chk_mask)
  );

  always_comb begin
    err_set               = '0;
    err_set[ERR_IDX_ILAS] = viol_evt;
    err_set[ERR_IDX_UNK]  = viol_evt | late_k_evt;
  end

  lsd_err_flags #(.N(ERR_COUNT)) err_i (
    .clk   (clk),
    .rst   (rst),
    .clr   (err_clear),
    .set   (err_set),
    .flag_q(err_q)
  );

  assign err_ilas    = err_q[ERR_IDX_ILAS];
  assign err_unexp_k = err_q[ERR_IDX_UNK];
endmodule

// File: rtl/lsd_checker.sv
module lsd_checker (
  input logic clk,
  input logic rst,
  input logic reinit,
  input logic rx_valid,
  input logic err_clear,
  input logic start_pulse,
  input logic chk_mask,
  input logic err_ilas,
  input logic err_unexp_k
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!start_pulse && !chk_mask && !err_ilas && !err_unexp_k))
    else $error("R1 outputs not cleared by reset");

  p_pulse_once_r2: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !start_pulse)
    else $error("R2 start pulse longer than one cycle");

  p_ilas_with_unk_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(err_ilas) |-> err_unexp_k)
    else $error("R3 ilas error without unexpected-K flag");

  p_mask_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(chk_mask) |-> start_pulse)
    else $error("R7 mask rose without start");

  p_start_masks_r8: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> chk_mask)
    else $error("R8 start without mask");

  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (err_ilas && !err_clear) |=> err_ilas)
    else $error("R10 ilas flag dropped without clear");

  p_reinit_r11: assert property (@(posedge clk) disable iff (rst)
    reinit |=> (!start_pulse && !chk_mask))
    else $error("R11 reinit did not clear pulse and mask");

  p_mask_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (chk_mask && !rx_valid && !reinit) |=> chk_mask)
    else $error("R12 mask moved on an idle cycle");
endmodule

bind lane_start_detect lsd_checker chk_i (
  .clk        (clk),
  .rst        (rst),
  .reinit     (reinit),
  .rx_valid   (rx_valid),
  .err_clear  (err_clear),
  .start_pulse(start_pulse),
  .chk_mask   (chk_mask),
  .err_ilas   (err_ilas),
  .err_unexp_k(err_unexp_k)
);

// File: tb/lane_start_detect_tb.sv
module lane_start_detect_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 5000;
  localparam int N_VEC = 8;
  localparam int DSCR_LEN = 8;
  localparam int DIRECT_LEN = 16;

  // vector: {valid, ctrl, data[7:0], exp_start, exp_ilas, exp_unk, exp_mask}
  localparam logic [13:0] VEC [N_VEC] = '{
    {1'b1, 1'b0, 8'h55, 4'b0000},  // R6 data before any /K/
    {1'b1, 1'b1, 8'hBC, 4'b0000},  // first /K/
    {1'b0, 1'b1, 8'h1C, 4'b0000},  // R12 idle /R/ ignored
    {1'b1, 1'b1, 8'hBC, 4'b0000},
    {1'b1, 1'b0, 8'hAA, 4'b0110},  // R3 data ends /K/ run in aligned mode
    {1'b1, 1'b1, 8'hBC, 4'b0110},
    {1'b1, 1'b1, 8'h1C, 4'b1111},  // R2 /K/ to /R/
    {1'b1, 1'b0, 8'h00, 4'b0111}   // R2 pulse over, R8 mask held
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reinit = 1'b0;
  logic lane_sync_en = 1'b1;
  logic rx_valid = 1'b0;
  logic rx_is_ctrl = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic err_clear = 1'b0;
  logic start_pulse, chk_mask, err_ilas, err_unexp_k;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_start_detect dut_i (
    .clk         (clk),
    .rst         (rst),
    .reinit      (reinit),
    .lane_sync_en(lane_sync_en),
    .rx_valid    (rx_valid),
    .rx_is_ctrl  (rx_is_ctrl),
    .rx_data     (rx_data),
    .err_clear   (err_clear),
    .start_pulse (start_pulse),
    .chk_mask    (chk_mask),
    .err_ilas    (err_ilas),
    .err_unexp_k (err_unexp_k)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic es, input logic ei,
                           input logic eu, input logic em);
    check(req, "start_pulse", start_pulse, es);
    check(req, "err_ilas", err_ilas, ei);
    check(req, "err_unexp_k", err_unexp_k, eu);
    check(req, "chk_mask", chk_mask, em);
  endtask

  // drive one cycle, then sample one time unit after the edge
  task automatic step(input logic v, input logic c, input logic [7:0] d);
    rx_valid = v;
    rx_is_ctrl = c;
    rx_data = d;
    @(posedge clk);
    #1;
    rx_valid = 1'b0;
    err_clear = 1'b0;
    reinit = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG_CYC) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG_CYC);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    check_all("R1", 1'b0, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < N_VEC; i++) begin
      step(VEC[i][13], VEC[i][12], VEC[i][11:4]);
      check_all($sformatf("R2/R3/R6 vec%0d", i), VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R8: 1 valid octet already counted; 6 more keep the mask, an idle keeps it (R12)
    for (int i = 0; i < DSCR_LEN - 2; i++) begin
      step(1'b1, 1'b0, 8'(i));
      check("R8", "chk_mask during window", chk_mask, 1'b1);
    end
    step(1'b0, 1'b0, 8'h00);
    check("R12", "chk_mask on idle", chk_mask, 1'b1);
    step(1'b1, 1'b0, 8'h77);
    check("R8", "chk_mask after last octet", chk_mask, 1'b0);

    // R10 clear, then R9 late /K/
    err_clear = 1'b1;
    step(1'b0, 1'b0, 8'h00);
    check("R10", "err_ilas cleared", err_ilas, 1'b0);
    check("R10", "err_unexp_k cleared", err_unexp_k, 1'b0);
    step(1'b1, 1'b1, 8'hBC);
    check("R9", "err_unexp_k on late K", err_unexp_k, 1'b1);
    check("R9", "err_ilas untouched", err_ilas, 1'b0);
    err_clear = 1'b1;
    step(1'b1, 1'b1, 8'hBC);
    check("R10", "set wins over clear", err_unexp_k, 1'b1);

    // R11 reinit keeps flags
    reinit = 1'b1;
    step(1'b0, 1'b0, 8'h00);
    check_all("R11", 1'b0, 1'b0, 1'b1, 1'b0);
    err_clear = 1'b1;
    step(1'b0, 1'b0, 8'h00);

    // R4 / R7 direct mode
    lane_sync_en = 1'b0;
    step(1'b1, 1'b1, 8'hBC);
    step(1'b1, 1'b1, 8'hBC);
    step(1'b1, 1'b0, 8'h12);
    check_all("R4", 1'b1, 1'b0, 1'b0, 1'b1);
    for (int i = 1; i <= DIRECT_LEN; i++) begin
      if (i == 5) begin
        step(1'b0, 1'b0, 8'h00);
        check("R12", "direct mask on idle", chk_mask, 1'b1);
      end
      step(1'b1, 1'b0, 8'(i + 32));
      check("R7", $sformatf("chk_mask after octet %0d", i), chk_mask, (i < DIRECT_LEN));
    end

    // R5 /R/ ends the /K/ run in direct mode, then back to hunting
    reinit = 1'b1;
    step(1'b0, 1'b0, 8'h00);
    step(1'b1, 1'b1, 8'hBC);
    step(1'b1, 1'b1, 8'h1C);
    check_all("R5", 1'b0, 1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 8'h33);
    check("R5", "no start without new K", start_pulse, 1'b0);
    step(1'b1, 1'b1, 8'hBC);
    step(1'b1, 1'b0, 8'h44);
    check("R4", "start after new K run", start_pulse, 1'b1);

    // R3 stray control character in aligned mode
    lane_sync_en = 1'b1;
    reinit = 1'b1;
    err_clear = 1'b1;
    step(1'b0, 1'b0, 8'h00);
    step(1'b1, 1'b1, 8'hBC);
    step(1'b1, 1'b1, 8'h7C);
    check_all("R3", 1'b0, 1'b1, 1'b1, 1'b0);

    // R1 reset mid-run
    rst = 1'b1;
    step(1'b0, 1'b0, 8'h00);
    rst = 1'b0;
    check_all("R1", 1'b0, 1'b0, 1'b0, 1'b0);

    finish_run();
  end
endmodule